// File: doc/BRIEF.md
# Stop-Frozen History Capture Buffer

This block keeps a rolling history of a 16-bit data stream. Every accepted word goes into a circular memory, and the write pointer wraps, so the memory always holds the most recent `DEPTH` words (2048 by default). A stop input freezes the history. It is asynchronous to the block clock, so it is first synchronised and then edge-detected. Once frozen, the block accepts no more words and raises a ready flag.

A host reads the frozen history through a small register port. A status register reports the ready flag and whether the memory has wrapped. A level register reports how many words are valid. Each read of the data register returns the next stored word, starting from the oldest. When the host writes the re-arm bit, the history is discarded and capture starts again.

Register map (2-bit address): 0 = status/control, 1 = level, 2 = data pop, 3 = unused.

Top module: `capture_ring_buffer`

## Requirements
- R1: After reset, `cap_ready` is 0, the status register reads 0 and the level register reads 0.
- R2: While armed, every word presented with `in_valid` high is stored. The level register counts stored words up to `DEPTH` and then stays at `DEPTH`, with the oldest word overwritten, so the buffer holds the last `DEPTH` words.
- R3: `stop_in` passes through a two-flop synchroniser. The word accepted at the rising edge that first samples `stop_in` high is stored, and so are the words at the next two rising edges. Every word after those is discarded until re-arm.
- R4: A stop event sets the ready flag. The flag appears on `cap_ready` and as status bit 0, from the same rising edge that stores the last word.
- R5: A stop level held high for many cycles is a single event. After a re-arm while `stop_in` is still high, no freeze occurs until `stop_in` goes low and then high again.
- R6: Status bit 1 (wrapped) becomes 1 once `DEPTH` words have been stored. It stays 1 until re-arm, and while it is set the level register reads `DEPTH`.
- R7: While the buffer is frozen, each read of address 2 returns the next stored word, oldest first, in arrival order. A read of address 2 while armed, or after all valid words have been read, returns 0 and does not advance the read position.
- R8: A write to address 0 with bit 0 set clears the ready flag, the wrapped flag, the level and the read position, and re-arms capture. A write with bit 0 clear, or a write to any other address, has no effect.
- R9: For every cycle with `reg_rd` high, `reg_rvalid` is high in the next cycle, with the read value on `reg_rdata`. Otherwise `reg_rvalid` and `reg_rdata` are 0.
- R10: A cycle with `in_valid` low stores nothing, and the words around it stay adjacent in the readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Incoming data word |
| in_valid | input | 1 | Qualifies `in_data` for storage |
| stop_in | input | 1 | Asynchronous stop request, active high |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | DATA_W | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read response, one cycle after `reg_rd` |
| cap_ready | output | 1 | Frozen history is ready for readout |

## Verification
The properties assume that the register strobes are single-cycle and synchronous to `clk`. They also assume that `stop_in` is the only asynchronous input and that reset is applied once before any stimulus. The bench drives all inputs on the falling clock edge. It drives `stop_in` as a level, and keeps it high long enough for the synchroniser to see it. Before each new stop edge it holds `stop_in` low for several cycles, so every intended edge is seen exactly once. Reads and writes are always separate one-cycle strobes, so a host read never overlaps a re-arm in a way the reference model would have to guess.

// File: rtl/cap_pkg.sv
package cap_pkg;

   // Register addresses of the host port
   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_LEVEL = 2'd1,
      REG_DATA  = 2'd2,
      REG_SPARE = 2'd3
   } cap_reg_e;

   localparam int STAT_READY_BIT = 0;
   localparam int STAT_WRAP_BIT  = 1;
   localparam int CTRL_REARM_BIT = 0;

endpackage

// File: rtl/cap_stop_sync.sv
module cap_stop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_async,
   output logic stop_evt
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("cap_stop_sync: STAGES must be at least 2");
   end

   // Synchroniser chain: bit 0 samples the raw input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], stop_async};
         last_q <= sync_q[STAGES-1];
      end
   end

   // One pulse per low-to-high transition of the synchronised level
   assign stop_evt = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/cap_ring_ctrl.sv
module cap_ring_ctrl #(
   parameter  int DEPTH = 2048,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             stop_evt,
   input  logic             rearm,
   output logic             wr_en,
   output logic [AW-1:0]    wr_ptr,
   output logic             wrapped,
   output logic             frozen,
   output logic [CNT_W-1:0] level
);

   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

   if (DEPTH < 4) begin : g_bad_depth
      $error("cap_ring_ctrl: DEPTH must be at least 4");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("cap_ring_ctrl: DEPTH must be a power of two");
   end

   // Words are taken only while armed; a re-arm cycle takes none
   assign wr_en = in_valid & ~frozen & ~rearm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         wrapped <= 1'b0;
      end else if (rearm) begin
         wr_ptr  <= '0;
         wrapped <= 1'b0;
      end else if (wr_en) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (wr_ptr == LAST_SLOT) begin
            wrapped <= 1'b1;
         end
      end
   end

   // Stop has priority: a re-arm and a stop in one cycle leave it frozen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen <= 1'b0;
      end else if (stop_evt) begin
         frozen <= 1'b1;
      end else if (rearm) begin
         frozen <= 1'b0;
      end
   end

   assign level = wrapped ? CNT_W'(DEPTH) : {1'b0, wr_ptr};

endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
   parameter  int DATA_W = 16,
   parameter  int DEPTH  = 2048,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   if (DATA_W < 1) begin : g_bad_width
      $error("cap_ram: DATA_W must be positive");
   end

   // Simple dual-port, registered read
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/cap_reg_if.sv
module cap_reg_if
   import cap_pkg::*;
#(
   parameter  int DATA_W = 16,
   parameter  int DEPTH  = 2048,
   localparam int AW     = $clog2(DEPTH),
   localparam int CNT_W  = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   input  logic              frozen,
   input  logic              wrapped,
   input  logic [AW-1:0]     wr_ptr,
   input  logic [CNT_W-1:0]  level,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rearm,
   output logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid
);

   if (CNT_W > DATA_W) begin : g_bad_level_width
      $error("cap_reg_if: level does not fit in a register word");
   end

   cap_reg_e          addr_e;
   logic [CNT_W-1:0]  rd_idx;
   logic              pop_ok;
   logic              pop_q;
   logic              rvalid_q;
   logic [DATA_W-1:0] csr_word;
   logic [DATA_W-1:0] csr_q;

   assign addr_e = cap_reg_e'(reg_addr);

   assign rearm = reg_wr && (addr_e == REG_CTRL) && reg_wdata[CTRL_REARM_BIT];

   // A data pop is honoured only from a frozen history with words left
   assign pop_ok = reg_rd && (addr_e == REG_DATA) && frozen && (rd_idx < level);

   // Oldest word sits at the write pointer once the ring has wrapped
   assign rd_addr = wrapped ? (wr_ptr + rd_idx[AW-1:0]) : rd_idx[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx <= '0;
      end else if (rearm) begin
         rd_idx <= '0;
      end else if (pop_ok) begin
         rd_idx <= rd_idx + 1'b1;
      end
   end

   always_comb begin
      csr_word = '0;
      unique case (addr_e)
         REG_CTRL: begin
            csr_word[STAT_READY_BIT] = frozen;
            csr_word[STAT_WRAP_BIT]  = wrapped;
         end
         REG_LEVEL: csr_word = DATA_W'(level);
         REG_DATA,
         REG_SPARE: csr_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         pop_q    <= 1'b0;
         csr_q    <= '0;
      end else begin
         rvalid_q <= reg_rd;
         pop_q    <= pop_ok;
         csr_q    <= reg_rd ? csr_word : '0;
      end
   end

   assign reg_rvalid = rvalid_q;
   assign reg_rdata  = !rvalid_q ? '0 : (pop_q ? mem_rdata : csr_q);

endmodule

// File: rtl/capture_ring_buffer.sv
module capture_ring_buffer #(
   parameter  int DATA_W      = 16,
   parameter  int DEPTH       = 2048,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH),
   localparam int CNT_W       = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              stop_in,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   output logic              cap_ready
);

   logic              stop_evt;
   logic              rearm;
   logic              wr_en;
   logic [AW-1:0]     wr_ptr;
   logic              wrapped;
   logic              frozen;
   logic [CNT_W-1:0]  level;
   logic [AW-1:0]     rd_addr;
   logic [DATA_W-1:0] mem_rdata;

   cap_stop_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_async (stop_in),
      .stop_evt   (stop_evt)
   );

   cap_ring_ctrl #(
      .DEPTH (DEPTH)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .stop_evt (stop_evt),
      .rearm    (rearm),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .wrapped  (wrapped),
      .frozen   (frozen),
      .level    (level)
   );

   cap_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_ptr),
      .wdata (in_data),
      .raddr (rd_addr),
      .rdata (mem_rdata)
   );

   cap_reg_if #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rd     (reg_rd),
      .frozen     (frozen),
      .wrapped    (wrapped),
      .wr_ptr     (wr_ptr),
      .level      (level),
      .mem_rdata  (mem_rdata),
      .rearm      (rearm),
      .rd_addr    (rd_addr),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid)
   );

   assign cap_ready = frozen;

endmodule

// File: rtl/cap_ring_chk.sv
module cap_ring_chk #(
   parameter  int DEPTH = 2048,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_evt,
   input logic             rearm,
   input logic             frozen,
   input logic             wrapped,
   input logic [AW-1:0]    wr_ptr,
   input logic [CNT_W-1:0] level,
   input logic             reg_rd,
   input logic             reg_rvalid,
   input logic             cap_ready
);

   // R2: the level never exceeds the memory depth
   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));

   // R3: a frozen history takes no writes
   a_r3_frozen_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !rearm) |=> (wr_ptr == $past(wr_ptr)));

   // R4: the ready flag follows a stop event and nothing else
   a_r4_stop_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> cap_ready);
   a_r4_ready_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_ready) |-> $past(stop_evt));

   // R5: a stop level yields one event
   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !stop_evt);

   // R6: the wrapped flag is sticky until re-arm
   a_r6_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped && !rearm) |=> wrapped);

   // R8: re-arm clears the capture state
   a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && !stop_evt) |=> (!frozen && !wrapped && (wr_ptr == '0)));

   // R9: each read gets exactly one response, one cycle later
   a_r9_read_response: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);
   a_r9_no_spurious_response: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid);

endmodule

bind capture_ring_buffer cap_ring_chk #(
   .DEPTH (DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_evt   (stop_evt),
   .rearm      (rearm),
   .frozen     (frozen),
   .wrapped    (wrapped),
   .wr_ptr     (wr_ptr),
   .level      (level),
   .reg_rd     (reg_rd),
   .reg_rvalid (reg_rvalid),
   .cap_ready  (cap_ready)
);

// File: tb/tb_capture_ring_buffer.sv
`timescale 1ns/1ps
module tb_capture_ring_buffer;

   localparam int DW    = 16;
   localparam int DEPTH = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_valid = 1'b0;
   logic          stop_in = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic          reg_rd = 1'b0;
   logic [DW-1:0] reg_rdata;
   logic          reg_rvalid;
   logic          cap_ready;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   capture_ring_buffer #(
      .DATA_W (DW),
      .DEPTH  (DEPTH)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .stop_in    (stop_in),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rd     (reg_rd),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .cap_ready  (cap_ready)
   );

   // ---------------- behavioural reference model ----------------
   int mq[$];
   bit m_ready, m_wrap, m_rv;
   bit m_s1, m_s2, m_s3;
   int m_ridx, m_rdata;
   bit m_evt, m_clr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete();
         m_ready = 0; m_wrap = 0; m_rv = 0; m_rdata = 0; m_ridx = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         m_evt = m_s2 && !m_s3;
         m_clr = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];
         m_rdata = 0;
         if (reg_rd) begin
            case (reg_addr)
               2'd0: m_rdata = (m_wrap ? 2 : 0) + (m_ready ? 1 : 0);
               2'd1: m_rdata = mq.size();
               2'd2: if (m_ready && m_ridx < mq.size()) begin
                  m_rdata = mq[m_ridx];
                  m_ridx++;
               end
               default: m_rdata = 0;
            endcase
         end
         m_rv = reg_rd;
         if (m_clr) begin
            mq.delete(); m_wrap = 0; m_ridx = 0;
         end else if (in_valid && !m_ready) begin
            mq.push_back(int'(in_data));
            if (mq.size() > DEPTH) void'(mq.pop_front());
            if (mq.size() == DEPTH) m_wrap = 1;
         end
         if (m_evt) m_ready = 1;
         else if (m_clr) m_ready = 0;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = stop_in;
      end
   end

   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // Compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R4 cap_ready vs model", int'(cap_ready), int'(m_ready));
         check("R9 reg_rvalid vs model", int'(reg_rvalid), int'(m_rv));
         check("R7 reg_rdata vs model", int'(reg_rdata), m_rv ? m_rdata : 0);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read(logic [1:0] a, output int v);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      v = int'(reg_rdata);
      reg_rd = 1'b0;
   endtask

   task automatic do_write(logic [1:0] a, int d);
      reg_addr = a; reg_wdata = DW'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // Streams n words base+k; stop_in rises together with word stop_k
   task automatic stream(int n, int base, int stop_k, bit gaps);
      for (int k = 0; k < n; k++) begin
         in_data  = DW'(base + k);
         in_valid = gaps ? (k % 3 != 2) : 1'b1;
         if (k == stop_k) stop_in = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int v;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // R1: reset state
      check("R1 cap_ready after reset", int'(cap_ready), 0);
      do_read(2'd0, v); check("R1 status after reset", v, 0);
      do_read(2'd1, v); check("R1 level after reset", v, 0);

      // R3/R4: stop with words 0..12 stored (stop seen with word 10)
      stream(16, 'h100, 10, 1'b0);
      cyc(2);
      check("R4 cap_ready after stop", int'(cap_ready), 1);
      do_read(2'd0, v); check("R4 status ready", v, 1);
      do_read(2'd1, v); check("R3 stored count", v, 13);
      for (int i = 0; i < 13; i++) begin
         do_read(2'd2, v); check("R7 oldest-first readout", v, 'h100 + i);
      end
      do_read(2'd2, v); check("R7 read past end returns 0", v, 0);
      do_read(2'd1, v); check("R7 level unchanged by pops", v, 13);
      stop_in = 1'b0;
      cyc(4);

      // R8: writes without the re-arm bit or to other addresses are ignored
      do_write(2'd0, 0); do_write(2'd3, 1); do_write(2'd1, 1); do_write(2'd2, 1);
      do_read(2'd0, v); check("R8 status kept after ignored writes", v, 1);
      do_read(2'd1, v); check("R8 level kept after ignored writes", v, 13);
      do_write(2'd0, 1);
      do_read(2'd0, v); check("R8 status cleared by re-arm", v, 0);
      do_read(2'd1, v); check("R8 level cleared by re-arm", v, 0);

      // R10: gaps in in_valid store nothing
      stream(12, 'h500, -1, 1'b1);
      stop_in = 1'b1; cyc(5);
      do_read(2'd1, v); check("R10 count with gaps", v, 8);
      do_read(2'd2, v); check("R10 first word", v, 'h500);
      do_read(2'd2, v); check("R10 second word", v, 'h501);
      do_read(2'd2, v); check("R10 gap skipped", v, 'h503);
      stop_in = 1'b0; cyc(4);
      do_write(2'd0, 1);

      // R2/R6: wrap, 143 words taken, last 64 kept (offsets 79..142)
      stream(150, 'h2000, 140, 1'b0);
      cyc(2);
      do_read(2'd0, v); check("R6 status wrapped and ready", v, 3);
      do_read(2'd1, v); check("R6 level saturates at depth", v, DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         do_read(2'd2, v); check("R2 last-depth words in order", v, 'h2000 + 79 + i);
      end

      // R5: re-arm with stop still high: no freeze until a new edge
      do_write(2'd0, 1);
      stream(20, 'h3000, -1, 1'b0);
      cyc(3);
      check("R5 no freeze from held stop", int'(cap_ready), 0);
      do_read(2'd1, v); check("R5 capture continues", v, 20);
      // R7: data read while armed returns 0 and does not advance
      do_read(2'd2, v); check("R7 armed data read is 0", v, 0);
      stop_in = 1'b0; cyc(4);
      stop_in = 1'b1; cyc(5);
      check("R5 new edge freezes", int'(cap_ready), 1);
      do_read(2'd2, v); check("R7 armed read did not advance", v, 'h3000);
      stop_in = 1'b0; cyc(4);
      do_write(2'd0, 1);
      do_read(2'd0, v); check("R8 final re-arm", v, 0);
      cyc(2);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule